// File: doc/BRIEF.md
# Overflow Status Flag Controller

This block owns the signed-overflow bit of an 8-bit processor status word. Each clock cycle it takes one decoded instruction class, the operand or memory data word, the overflow result of the arithmetic unit, a byte pulled from the stack, and a data-width mode bit. From these it decides whether the bit is loaded, forced or held. The arithmetic itself, instruction decoding and the other status bits belong to neighbouring logic.

An external active-low pin can also set the flag on its own. Software can use this to wait for a hardware event: it clears the flag, then spins on a branch until the flag reads set. The pin is asynchronous. It passes through a two-flop synchronizer, and only a high-to-low transition of the synchronized level sets the flag. That hardware set wins over any instruction write in the same cycle. Software alone clears the flag again.

For bit-test instructions the tapped operand bit follows the data width. Byte mode taps bit 6 and wide (16-bit) mode taps bit 14, which is bit 6 of the upper byte.

Top module: `ovf_flag_ctl`

## Requirements
- R1: While `rst_n` is low, `v_flag` is 0 and the pin synchronizer holds the idle-high level. If `set_ovf_n` is high when reset is released, `v_flag` stays 0 afterwards.
- R2: Instruction class 1 (clear) makes `v_flag` 0 from the next rising edge.
- R3: Class 2 (status pull) loads `v_flag` from bit 6 of `pull_byte`.
- R4: Class 3 (bit-test from memory) with `wide_mode` = 0 loads `v_flag` from bit 6 of `data_in`. For example, 0x00AB gives 0 and 0x0040 gives 1, and bit 14 is ignored.
- R5: Class 3 with `wide_mode` = 1 loads `v_flag` from bit 14 of `data_in`, and bit 6 is ignored.
- R6: Class 4 (bit-test immediate) leaves `v_flag` unchanged, whatever the value of `data_in`.
- R7: Class 5 (add/subtract) loads `v_flag` from `alu_ovf`.
- R8: Class 6 (mask clear) makes `v_flag` 0 only when bit 6 of `data_in` is 1. Otherwise the flag is unchanged.
- R9: Class 7 (mask set) makes `v_flag` 1 only when bit 6 of `data_in` is 1. Otherwise the flag is unchanged.
- R10: A high-to-low transition of `set_ovf_n` sets `v_flag`. If the low level is first captured at rising edge k, `v_flag` reads 1 after edge k+2. A pin that stays low, or a rising transition, sets nothing further.
- R11: When the pin set and an instruction write fall on the same edge, the flag becomes 1.
- R12: Class 0 (no operation) leaves `v_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_cls | input | 3 | Instruction class: 0 none, 1 clear, 2 pull, 3 bit-test memory, 4 bit-test immediate, 5 add/subtract, 6 mask clear, 7 mask set |
| data_in | input | 16 | Operand or memory data word |
| alu_ovf | input | 1 | Overflow result of the arithmetic unit |
| pull_byte | input | 8 | Status byte pulled from the stack |
| wide_mode | input | 1 | 1 selects 16-bit data width for bit-test |
| set_ovf_n | input | 1 | Asynchronous active-low set pin |
| v_flag | output | 1 | Overflow status bit |

## Verification
On every cycle, the assertions check how each instruction class acts on the flag one edge later, as long as no pin pulse is active. They also check that a synchronized pin pulse always leaves the flag set, and that such a pulse never lasts two cycles. Some behaviours show up only in the bench's scenarios. These are the two-edge latency from the pin to the flag, that a steady low pin does not set the flag again after a clear, that a pulse beats a clear issued in the same cycle, and the quiet state after reset. The bench's cycle-by-cycle model checks them.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CLRV    = 3'd1,
        OP_PULL    = 3'd2,
        OP_BITMEM  = 3'd3,
        OP_BITIMM  = 3'd4,
        OP_ARITH   = 3'd5,
        OP_MASKCLR = 3'd6,
        OP_MASKSET = 3'd7
    } ovf_op_e;

    typedef struct packed {
        logic v;
    } ovf_state_t;

    typedef struct packed {
        logic wr_en;
        logic wr_val;
    } ovf_write_t;

endpackage

// File: rtl/ovf_pin_sync.sv
module ovf_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign fall_pulse = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse) else $error("pulse lasted two cycles"); // R10

endmodule

// File: rtl/ovf_src_sel.sv
module ovf_src_sel
    import ovf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int OVF_BIT = 6
) (
    input  ovf_op_e              op,
    input  logic [DATA_W-1:0]    data_in,
    input  logic                 alu_ovf,
    input  logic [BYTE_W-1:0]    pull_byte,
    input  logic                 wide_mode,
    output ovf_write_t           wr
);
    localparam int WIDE_IDX = BYTE_W + OVF_BIT;

    logic narrow_tap, wide_tap, test_tap;
    logic unused_ok;

    assign narrow_tap = data_in[OVF_BIT];

    generate
        if (DATA_W > WIDE_IDX) begin : g_wide
            assign wide_tap = data_in[WIDE_IDX];
        end else begin : g_narrow_only
            assign wide_tap = data_in[OVF_BIT];
        end
    endgenerate

    assign test_tap  = wide_mode ? wide_tap : narrow_tap;
    assign unused_ok = ^{data_in, pull_byte};

    always_comb begin
        wr = '{wr_en: 1'b0, wr_val: 1'b0};
        unique case (op)
            OP_CLRV:    wr = '{wr_en: 1'b1, wr_val: 1'b0};
            OP_PULL:    wr = '{wr_en: 1'b1, wr_val: pull_byte[OVF_BIT]};
            OP_BITMEM:  wr = '{wr_en: 1'b1, wr_val: test_tap};
            OP_ARITH:   wr = '{wr_en: 1'b1, wr_val: alu_ovf};
            OP_MASKCLR: wr = '{wr_en: narrow_tap, wr_val: 1'b0};
            OP_MASKSET: wr = '{wr_en: narrow_tap, wr_val: 1'b1};
            default:    wr = '{wr_en: 1'b0, wr_val: 1'b0};
        endcase
    end

endmodule

// File: rtl/ovf_flag_ctl.sv
module ovf_flag_ctl
    import ovf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int OVF_BIT = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_cls,
    input  logic [DATA_W-1:0] data_in,
    input  logic              alu_ovf,
    input  logic [BYTE_W-1:0] pull_byte,
    input  logic              wide_mode,
    input  logic              set_ovf_n,
    output logic              v_flag
);
    localparam int WIDE_IDX = BYTE_W + OVF_BIT;

    ovf_op_e    op;
    ovf_write_t wr;
    ovf_state_t st_d, st_q;
    logic       pin_fall;

    assign op = ovf_op_e'(op_cls);

    ovf_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (set_ovf_n),
        .fall_pulse (pin_fall)
    );

    ovf_src_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .OVF_BIT(OVF_BIT)) i_sel (
        .op        (op),
        .data_in   (data_in),
        .alu_ovf   (alu_ovf),
        .pull_byte (pull_byte),
        .wide_mode (wide_mode),
        .wr        (wr)
    );

    // Hardware set is applied last so it wins over any instruction write.
    always_comb begin
        st_d = st_q;
        if (wr.wr_en) st_d.v = wr.wr_val;
        if (pin_fall) st_d.v = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{v: 1'b0};
        else        st_q <= st_d;
    end

    assign v_flag = st_q.v;

    AST_CLEAR_V: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLRV && !pin_fall) |=> !v_flag) else $error("clear failed"); // R2
    AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PULL && !pin_fall) |=> (v_flag == $past(pull_byte[OVF_BIT]))) else $error("pull"); // R3
    AST_BIT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BITMEM && !wide_mode && !pin_fall) |=> (v_flag == $past(data_in[OVF_BIT]))) else $error("bit8"); // R4
    generate
        if (DATA_W > WIDE_IDX) begin : g_wide_chk
            AST_BIT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_BITMEM && wide_mode && !pin_fall) |=> (v_flag == $past(data_in[WIDE_IDX]))) else $error("bit16"); // R5
        end
    endgenerate
    AST_IMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BITIMM && !pin_fall) |=> $stable(v_flag)) else $error("imm"); // R6
    AST_ARITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ARITH && !pin_fall) |=> (v_flag == $past(alu_ovf))) else $error("arith"); // R7
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MASKCLR && data_in[OVF_BIT] && !pin_fall) |=> !v_flag) else $error("mclr"); // R8
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MASKSET && data_in[OVF_BIT]) |=> v_flag) else $error("mset"); // R9
    AST_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> v_flag) else $error("pin"); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && !pin_fall) |=> $stable(v_flag)) else $error("idle"); // R12

endmodule

// File: tb/test_ovf_flag_ctl.sv
module test_ovf_flag_ctl;
    localparam int CLK_HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_cls = 3'd0;
    logic [15:0] data_in = 16'h0;
    logic        alu_ovf = 1'b0;
    logic [7:0]  pull_byte = 8'h0;
    logic        wide_mode = 1'b0;
    logic        set_ovf_n = 1'b1;
    logic        v_flag;

    int    n_checks = 0;
    int    n_errs = 0;
    bit    done = 0;
    string tag = "R1";

    logic  mv = 1'b0;
    logic  pin_q[$];

    always #CLK_HALF clk = ~clk;

    ovf_flag_ctl i_ovf_flag_ctl (
        .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .data_in(data_in),
        .alu_ovf(alu_ovf), .pull_byte(pull_byte), .wide_mode(wide_mode),
        .set_ovf_n(set_ovf_n), .v_flag(v_flag)
    );

    task automatic chk(input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: v_flag=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update the model at the edge, compare after it.
    task automatic step(input int op, input logic [15:0] d, input logic a,
                        input logic [7:0] p, input logic w, input logic pin);
        logic edge_seen;
        @(negedge clk);
        op_cls = op[2:0]; data_in = d; alu_ovf = a; pull_byte = p;
        wide_mode = w; set_ovf_n = pin;
        @(posedge clk);
        edge_seen = (pin_q[pin_q.size()-3] == 1'b1) && (pin_q[pin_q.size()-2] == 1'b0);
        pin_q.push_back(pin);
        case (op)
            1: mv = 1'b0;
            2: mv = p[6];
            3: mv = w ? d[14] : d[6];
            5: mv = a;
            6: if (d[6]) mv = 1'b0;
            7: if (d[6]) mv = 1'b1;
            default: ;
        endcase
        if (edge_seen) mv = 1'b1;
        #1;
        chk(v_flag, mv);
    endtask

    task automatic idle(input int n, input logic pin);
        for (int i = 0; i < n; i++) step(0, 16'h0, 1'b0, 8'h0, 1'b0, pin);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        pin_q = '{1'b1, 1'b1, 1'b1};
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 chk(v_flag, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        idle(4, 1'b1);

        tag = "R9"; step(7, 16'h0040, 0, 8'h00, 0, 1); step(7, 16'h00BF, 0, 8'h00, 0, 1);
        tag = "R2"; step(1, 16'hFFFF, 1, 8'hFF, 0, 1);
        tag = "R9"; step(7, 16'h0001, 0, 8'h00, 0, 1);
        tag = "R3"; step(2, 16'h0, 0, 8'h40, 0, 1); step(2, 16'h0, 0, 8'hBF, 0, 1);
        tag = "R4"; step(3, 16'h00AB, 0, 8'h00, 0, 1); step(3, 16'h0040, 0, 8'h00, 0, 1);
                    step(3, 16'h40AB, 0, 8'h00, 0, 1);
        tag = "R5"; step(3, 16'h4000, 0, 8'h00, 1, 1); step(3, 16'h0040, 0, 8'h00, 1, 1);
        tag = "R6"; step(4, 16'hFFFF, 0, 8'hFF, 1, 1); step(7, 16'h0040, 0, 8'h00, 0, 1);
                    step(4, 16'h0000, 0, 8'h00, 0, 1);
        tag = "R8"; step(6, 16'h00BF, 0, 8'h00, 0, 1); step(6, 16'h0040, 0, 8'h00, 0, 1);
        tag = "R7"; step(5, 16'h0, 1, 8'h00, 0, 1); step(5, 16'h0, 0, 8'h00, 0, 1);
                    step(5, 16'h0, 1, 8'h00, 0, 1);
        tag = "R12"; idle(3, 1'b1);
        tag = "R2"; step(1, 16'h0, 0, 8'h00, 0, 1);

        tag = "R10"; idle(5, 1'b0);
        step(1, 16'h0, 0, 8'h00, 0, 0); idle(4, 1'b0);
        idle(4, 1'b1);

        tag = "R11";
        for (int i = 0; i < 4; i++) step(1, 16'h0, 0, 8'h00, 0, 0);
        step(1, 16'h0, 0, 8'h00, 0, 0);
        idle(2, 1'b1);
        step(5, 16'h0, 0, 8'h00, 0, 1);
        for (int i = 0; i < 4; i++) step(6, 16'h0040, 0, 8'h00, 0, 0);

        tag = "R12"; idle(3, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule